// File: doc/BRIEF.md
# SPI Register Target with Write-Protection Key

This block is a four-wire SPI target that gives a host processor byte-wide read and write access to a 128-location register space. The host lowers chip select, sends a command byte and then one or more data bytes. The top bit of the command picks the direction, and the remaining seven bits give the first location. Each later data byte moves to the next location. The location pointer wraps from the top of the space back to zero. The serial lines are sampled in the block's own system clock domain. Every accepted write is also shown on a one-cycle strobe, so that the logic behind the registers can act on it.

A band of locations, 0x11 up to 0x27, can always be read but ignores writes while it is protected. To open the band, the host writes a two-byte key to the key location 0x10: first 0xBA, then 0xBE. The two writes must be data bytes that follow each other with no other data byte between them. The band then stays open until the host writes to 0x10 any byte other than 0xBA, or until reset. The key location itself stores nothing. A read of it reports whether the band is open.

Top module: `spi_lockable_regs`

## Requirements
- R1: While `spi_cs_n` is high, `spi_miso_oe` is low and activity on `spi_sclk` and `spi_mosi` neither writes any location nor produces a `wr_valid` pulse.
- R2: Data bits move most significant bit first. `spi_mosi` is sampled on the rising edge of `spi_sclk`, and `spi_miso` changes only after a falling edge of `spi_sclk`.
- R3: In the first byte of a transaction, bit 7 set to 1 means write and bit 7 set to 0 means read. Bits 6..0 give the starting location. The first byte itself never writes.
- R4: Each data byte after the first one in a transaction goes to the location after the previous one, and location 0x7F is followed by 0x00.
- R5: Read data for a byte is taken from storage at the end of the byte before it, so the bit 7 of the first data byte is on `spi_miso` after the first falling edge that follows the command byte.
- R6: Locations 0x11 through 0x27 can always be read. A write to one of them while the band is locked is dropped with no `wr_valid` pulse, and the pointer still advances to the next location.
- R7: Writing 0xBA to 0x10 and then 0xBE to 0x10, as consecutive data bytes, opens the protected band.
- R8: Any other data byte, read or write, between the 0xBA and the 0xBE cancels the sequence, and the band stays locked.
- R9: An open band stays open through reads and through writes of 0xBA to 0x10. Writing any other value to 0x10 locks it again.
- R10: A read of location 0x10 returns 0x01 while the band is open and 0x00 while it is locked, even in the middle of the key sequence.
- R11: If chip select rises before a data byte is complete, that byte is dropped with no write and no `wr_valid` pulse.
- R12: After reset the band is locked, every stored location reads 0x00, and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, valid while `spi_miso_oe` is high |
| spi_miso_oe | output | 1 | Output enable for the serial data pad; low means high impedance |
| wr_valid | output | 1 | One-cycle strobe for each accepted write |
| wr_addr | output | 7 | Location of the accepted write |
| wr_data | output | 8 | Data of the accepted write |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, the band from 0x11 to 0x27, and the key bytes 0xBA and 0xBE at location 0x10. With the serial clock at one sixteenth of the system clock, the path of three registers from a falling edge to `spi_miso` fits well inside half a serial period. This lets the bench sample read data just before each rising edge, as a host would. Bursts that start at 0x7E and at 0x27 reach both the pointer wrap and the top edge of the band. Counting `wr_valid` pulses shows at the ports which writes were dropped.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
   // Frame geometry is fixed by the command byte layout.
   localparam int unsigned SPI_BYTE_W = 8;
   localparam int unsigned SPI_ADDR_W = 7;

   typedef enum logic [1:0] {
      LK_LOCKED = 2'd0,
      LK_HALF   = 2'd1,
      LK_OPEN   = 2'd2
   } lock_state_t;

   // One completed data byte, produced by the frame engine.
   typedef struct packed {
      logic                  valid;
      logic                  write;
      logic [SPI_ADDR_W-1:0] addr;
      logic [SPI_BYTE_W-1:0] data;
   } byte_ev_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int unsigned    STAGES  = 2,
   parameter int unsigned    WIDTH   = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q_out = d_in;
      end else begin : g_chain
         logic [WIDTH-1:0] chain [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      chain[s] <= RST_VAL;
               else if (s == 0) chain[s] <= d_in;
               else             chain[s] <= chain[s-1];
            end
         end
         assign q_out = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
   import spi_regs_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sclk_s,
   input  logic                  cs_n_s,
   input  logic                  mosi_s,
   input  logic [SPI_BYTE_W-1:0] rd_data,
   output logic [SPI_ADDR_W-1:0] rd_addr,
   output byte_ev_t              ev,
   output logic                  miso,
   output logic                  miso_oe
);
   localparam int unsigned CNT_W = $clog2(SPI_BYTE_W);

   logic                  sclk_d;
   logic [CNT_W-1:0]      bit_cnt;
   logic [SPI_BYTE_W-1:0] rx_sh, tx_sh;
   logic                  in_cmd, wr_mode;
   logic [SPI_ADDR_W-1:0] ptr;

   wire                  active   = ~cs_n_s;
   wire                  rise     = active & sclk_s & ~sclk_d;
   wire                  fall     = active & ~sclk_s & sclk_d;
   wire [SPI_BYTE_W-1:0] rx_next  = {rx_sh[SPI_BYTE_W-2:0], mosi_s};
   wire                  byte_end = rise && (bit_cnt == CNT_W'(SPI_BYTE_W-1));

   // Prefetch address: the starting location at the end of the command,
   // the following location at the end of each data byte.
   assign rd_addr = in_cmd ? rx_next[SPI_ADDR_W-1:0] : ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         in_cmd  <= 1'b1;
         wr_mode <= 1'b0;
         ptr     <= '0;
         ev      <= '0;
         miso    <= 1'b0;
         miso_oe <= 1'b0;
      end else begin
         sclk_d   <= sclk_s;
         ev.valid <= 1'b0;
         miso_oe  <= active;
         if (!active) begin
            bit_cnt <= '0;
            in_cmd  <= 1'b1;
            tx_sh   <= '0;
            miso    <= 1'b0;
         end else begin
            if (rise) begin
               rx_sh   <= rx_next;
               bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (byte_end) begin
               if (in_cmd) begin
                  in_cmd  <= 1'b0;
                  wr_mode <= rx_next[SPI_BYTE_W-1];
                  ptr     <= rx_next[SPI_ADDR_W-1:0];
                  tx_sh   <= rx_next[SPI_BYTE_W-1] ? '0 : rd_data;
               end else begin
                  ev    <= '{valid: 1'b1, write: wr_mode, addr: ptr, data: rx_next};
                  ptr   <= ptr + 1'b1;
                  tx_sh <= wr_mode ? '0 : rd_data;
               end
            end
            if (fall) begin
               miso  <= tx_sh[SPI_BYTE_W-1];
               tx_sh <= {tx_sh[SPI_BYTE_W-2:0], 1'b0};
            end
         end
      end
   end

   assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !miso_oe);
   assert_no_cmd_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && in_cmd) |=> !ev.valid);
   assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_end && !in_cmd) |=> (ptr == $past(ptr) + 7'd1));
   assert_abort_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> !ev.valid);
   assert_miso_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !fall && $past(active)) |=> $stable(miso));
endmodule

// File: rtl/spi_lock_fsm.sv
module spi_lock_fsm
   import spi_regs_pkg::*;
#(
   parameter logic [SPI_ADDR_W-1:0] KEY_ADDR = 7'h10,
   parameter logic [SPI_BYTE_W-1:0] KEY_A    = 8'hBA,
   parameter logic [SPI_BYTE_W-1:0] KEY_B    = 8'hBE
) (
   input  logic     clk,
   input  logic     rst_n,
   input  byte_ev_t ev,
   output logic     unlocked
);
   lock_state_t state, state_nx;

   wire key_wr = ev.valid && ev.write && (ev.addr == KEY_ADDR);

   always_comb begin
      state_nx = state;
      unique case (state)
         LK_LOCKED: if (key_wr && ev.data == KEY_A) state_nx = LK_HALF;
         LK_HALF: if (ev.valid) begin
            if (key_wr && ev.data == KEY_B)      state_nx = LK_OPEN;
            else if (key_wr && ev.data == KEY_A) state_nx = LK_HALF;
            else                                 state_nx = LK_LOCKED;
         end
         LK_OPEN: if (key_wr && ev.data != KEY_A) state_nx = LK_LOCKED;
         default: state_nx = LK_LOCKED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= LK_LOCKED;
      else        state <= state_nx;
   end

   assign unlocked = (state == LK_OPEN);

   assert_open_needs_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != LK_OPEN && !(key_wr && ev.data == KEY_B)) |=> state != LK_OPEN);
   assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_HALF && ev.valid && !(key_wr && (ev.data == KEY_A || ev.data == KEY_B)))
      |=> state == LK_LOCKED);
   assert_stay_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == LK_OPEN && !(key_wr && ev.data != KEY_A)) |=> state == LK_OPEN);
endmodule

// File: rtl/spi_reg_store.sv
module spi_reg_store
   import spi_regs_pkg::*;
#(
   parameter int unsigned           DEPTH    = 128,
   parameter logic [SPI_ADDR_W-1:0] PROT_LO  = 7'h11,
   parameter logic [SPI_ADDR_W-1:0] PROT_HI  = 7'h27,
   parameter logic [SPI_ADDR_W-1:0] KEY_ADDR = 7'h10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  byte_ev_t              ev,
   input  logic                  unlocked,
   input  logic [SPI_ADDR_W-1:0] rd_addr,
   output logic [SPI_BYTE_W-1:0] rd_data,
   output logic                  wr_valid,
   output logic [SPI_ADDR_W-1:0] wr_addr,
   output logic [SPI_BYTE_W-1:0] wr_data
);
   logic [SPI_BYTE_W-1:0] mem [DEPTH];

   wire in_band = (ev.addr >= PROT_LO) && (ev.addr <= PROT_HI);

   assign wr_valid = ev.valid && ev.write && (ev.addr != KEY_ADDR) && (!in_band || unlocked);
   assign wr_addr  = ev.addr;
   assign wr_data  = ev.data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_valid) begin
         mem[wr_addr] <= wr_data;
      end
   end

   assign rd_data = (rd_addr == KEY_ADDR) ? SPI_BYTE_W'(unlocked) : mem[rd_addr];

   assert_band_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.valid && ev.write && in_band && !unlocked) |-> !wr_valid);
endmodule

// File: rtl/spi_lockable_regs.sv
module spi_lockable_regs
   import spi_regs_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PROT_LO     = 'h11,
   parameter int unsigned PROT_HI     = 'h27,
   parameter int unsigned KEY_ADDR    = 'h10,
   parameter int unsigned KEY_A       = 'hBA,
   parameter int unsigned KEY_B       = 'hBE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  spi_sclk,
   input  logic                  spi_cs_n,
   input  logic                  spi_mosi,
   output logic                  spi_miso,
   output logic                  spi_miso_oe,
   output logic                  wr_valid,
   output logic [SPI_ADDR_W-1:0] wr_addr,
   output logic [SPI_BYTE_W-1:0] wr_data
);
   localparam int unsigned DEPTH = 1 << SPI_ADDR_W;

   generate
      if (PROT_LO > PROT_HI || PROT_HI >= DEPTH) begin : g_bad_band
         $error("protected band bounds invalid");
      end
      if (KEY_ADDR >= PROT_LO && KEY_ADDR <= PROT_HI) begin : g_bad_key
         $error("key location lies inside the protected band");
      end
      if (KEY_A == KEY_B || KEY_A >= (1 << SPI_BYTE_W) || KEY_B >= (1 << SPI_BYTE_W)) begin : g_bad_keys
         $error("key bytes must differ and fit one byte");
      end
   endgenerate

   logic [2:0]            pins_s;
   logic [SPI_ADDR_W-1:0] rd_addr;
   logic [SPI_BYTE_W-1:0] rd_data;
   byte_ev_t              ev;
   logic                  unlocked;

   spi_pin_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({spi_mosi, spi_cs_n, spi_sclk}),
      .q_out (pins_s)
   );

   spi_frame_engine u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk_s  (pins_s[0]),
      .cs_n_s  (pins_s[1]),
      .mosi_s  (pins_s[2]),
      .rd_data (rd_data),
      .rd_addr (rd_addr),
      .ev      (ev),
      .miso    (spi_miso),
      .miso_oe (spi_miso_oe)
   );

   spi_lock_fsm #(
      .KEY_ADDR (SPI_ADDR_W'(KEY_ADDR)),
      .KEY_A    (SPI_BYTE_W'(KEY_A)),
      .KEY_B    (SPI_BYTE_W'(KEY_B))
   ) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .unlocked (unlocked)
   );

   spi_reg_store #(
      .DEPTH    (DEPTH),
      .PROT_LO  (SPI_ADDR_W'(PROT_LO)),
      .PROT_HI  (SPI_ADDR_W'(PROT_HI)),
      .KEY_ADDR (SPI_ADDR_W'(KEY_ADDR))
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .unlocked (unlocked),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );
endmodule

// File: tb/sim_spi_lockable_regs.sv
`timescale 1ns/1ps
module sim_spi_lockable_regs;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic       miso, miso_oe, wr_valid;
   logic [6:0] wr_addr;
   logic [7:0] wr_data;

   int  n_checks = 0, n_fail = 0, wr_cnt = 0;
   bit  done = 0;
   logic [6:0] last_wr_addr;
   logic [7:0] txb [16];
   logic [7:0] rxb [16];
   logic       oe_seen;

   always #2.5 clk = ~clk;

   spi_lockable_regs u0 (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always @(posedge clk) if (wr_valid) begin
      wr_cnt <= wr_cnt + 1;
      last_wr_addr <= wr_addr;
   end

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic half();
      repeat (8) @(negedge clk);
   endtask

   // Sends nbytes full bytes from txb, then extra_bits bits of txb[nbytes].
   task automatic xfer(input int nbytes, input int extra_bits);
      cs_n = 1'b0;
      half();
      for (int k = 0; k <= nbytes; k++) begin
         int nb;
         nb = (k < nbytes) ? 8 : extra_bits;
         rxb[k] = 8'h00;
         for (int b = 7; b > 7 - nb; b--) begin
            mosi = txb[k][b];
            half();
            rxb[k][b] = miso;
            sclk = 1'b1;
            half();
            sclk = 1'b0;
         end
      end
      half();
      cs_n = 1'b1;
      repeat (4) half();
   endtask

   task automatic wr1(input logic [6:0] a, input logic [7:0] d);
      txb[0] = {1'b1, a}; txb[1] = d;
      xfer(2, 0);
   endtask

   task automatic rd1(input logic [6:0] a, output logic [7:0] d);
      txb[0] = {1'b0, a}; txb[1] = 8'h00;
      xfer(2, 0);
      d = rxb[1];
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R12 oe after reset", {7'd0, miso_oe}, 8'h00);
      rd1(7'h10, d); check("R12 band locked at reset", d, 8'h00);
      rd1(7'h05, d); check("R12 storage zero at reset", d, 8'h00);
      rd1(7'h7F, d); check("R12 top storage zero at reset", d, 8'h00);
   endtask

   task automatic t_basic();
      logic [7:0] d;
      int c0;
      c0 = wr_cnt;
      wr1(7'h05, 8'h3C);
      check("R3 write strobe count", 8'(wr_cnt - c0), 8'd1);
      check("R3 write strobe addr", {1'b0, last_wr_addr}, 8'h05);
      rd1(7'h05, d); check("R2 read back msb-first", d, 8'h3C);
      wr1(7'h06, 8'h81);
      rd1(7'h06, d); check("R2 edge bits pattern", d, 8'h81);
   endtask

   task automatic t_wrap();
      txb[0] = 8'hFE; txb[1] = 8'hA1; txb[2] = 8'hA2; txb[3] = 8'hA3;
      xfer(4, 0);
      txb[0] = 8'h7E; txb[1] = 0; txb[2] = 0; txb[3] = 0;
      xfer(4, 0);
      check("R5 first prefetched byte", rxb[1], 8'hA1);
      check("R4 incremented to 0x7F", rxb[2], 8'hA2);
      check("R4 wrapped to 0x00", rxb[3], 8'hA3);
      check("R3 command byte drives zeros", rxb[0], 8'h00);
   endtask

   task automatic t_cs_idle();
      logic [7:0] d;
      int c0;
      logic [15:0] pat;
      c0 = wr_cnt; oe_seen = 1'b0; pat = 16'h85FF;
      for (int b = 15; b >= 0; b--) begin
         mosi = pat[b];
         half(); oe_seen |= miso_oe;
         sclk = 1'b1;
         half(); oe_seen |= miso_oe;
         sclk = 1'b0;
      end
      repeat (2) half();
      check("R1 oe low while deselected", {7'd0, oe_seen}, 8'h00);
      check("R1 no strobe while deselected", 8'(wr_cnt - c0), 8'd0);
      rd1(7'h05, d); check("R1 location unchanged", d, 8'h3C);
   endtask

   task automatic t_abort();
      logic [7:0] d;
      int c0;
      c0 = wr_cnt;
      txb[0] = 8'h85; txb[1] = 8'hF0;
      xfer(1, 4);
      check("R11 no strobe on partial byte", 8'(wr_cnt - c0), 8'd0);
      rd1(7'h05, d); check("R11 location unchanged", d, 8'h3C);
   endtask

   task automatic t_locked();
      logic [7:0] d;
      int c0;
      c0 = wr_cnt;
      txb[0] = {1'b1, 7'h27}; txb[1] = 8'h11; txb[2] = 8'h22;
      xfer(3, 0);
      check("R6 only unprotected write strobed", 8'(wr_cnt - c0), 8'd1);
      check("R6 pointer advanced past band", {1'b0, last_wr_addr}, 8'h28);
      rd1(7'h27, d); check("R6 protected write dropped", d, 8'h00);
      rd1(7'h28, d); check("R6 next location written", d, 8'h22);
      rd1(7'h11, d); check("R6 band readable while locked", d, 8'h00);
   endtask

   task automatic t_cancel();
      logic [7:0] d;
      wr1(7'h10, 8'hBA);
      rd1(7'h10, d); check("R10 mid-sequence reads locked", d, 8'h00);
      wr1(7'h10, 8'hBE);
      rd1(7'h10, d); check("R8 read between keys cancels", d, 8'h00);
      wr1(7'h10, 8'hBA);
      wr1(7'h04, 8'h77);
      wr1(7'h10, 8'hBE);
      wr1(7'h27, 8'h99);
      rd1(7'h27, d); check("R8 write between keys cancels", d, 8'h00);
   endtask

   task automatic t_unlock();
      logic [7:0] d;
      wr1(7'h10, 8'hBA);
      wr1(7'h10, 8'hBE);
      rd1(7'h10, d); check("R10 open status", d, 8'h01);
      wr1(7'h27, 8'h99);
      rd1(7'h27, d); check("R7 band writable when open", d, 8'h99);
      wr1(7'h11, 8'h5A);
      rd1(7'h11, d); check("R7 band low edge writable", d, 8'h5A);
   endtask

   task automatic t_relock();
      logic [7:0] d;
      wr1(7'h10, 8'hBA);
      rd1(7'h10, d); check("R9 key A keeps band open", d, 8'h01);
      wr1(7'h10, 8'h00);
      rd1(7'h10, d); check("R9 other byte locks", d, 8'h00);
      wr1(7'h27, 8'h44);
      rd1(7'h27, d); check("R9 band protected again", d, 8'h99);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_basic();
      t_wrap();
      t_cs_idle();
      t_abort();
      t_locked();
      t_cancel();
      t_unlock();
      t_relock();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule